// File: doc/BRIEF.md
# Serial Transmitter with Line Break and Hardware Handshake

This block turns queued bytes into an asynchronous serial stream. Each frame has one start bit, eight data bits and one stop bit. A 64-entry queue accepts bytes through a write strobe, and the queue fill is reported as an 8-bit count. The bit period is the rate input plus one, times 14 clock cycles. A control bit holds the line low to send a break for as long as that bit is set.

Both sides of hardware handshaking are built in. On the sending side, an enabled clear-to-send input gates the start of each frame, and a frame that has already started always runs to its end. On the receiving side, a request-to-send output is derived from the fill level of an external receive queue compared against one of four thresholds. Each of the two handshake signals has its own polarity control. The receive path itself is outside this block.

Top module: `hs_serial_tx`

## Requirements
- R1: After synchronous reset the serial line is high, the queue level is 0, and the line stays high whenever no frame is being sent and no break is forced.
- R2: Every frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit. Each bit lasts 14*(rate+1) clock cycles.
- R3: Bytes are sent in the order they were written. The level output counts the bytes waiting in the queue, and 0 means nothing is queued.
- R4: While control bit 8 is 1, the serial line is 0. After the bit clears, the line returns to its normal value.
- R5: While control bit 14 is 1 and clear-to-send is inactive, no new frame starts and queued bytes stay counted in the level. A frame already started finishes intact.
- R6: With control bit 15 at 0, clear-to-send is active when the input is 1. With control bit 15 at 1, it is active when the input is 0.
- R7: The queue holds 64 bytes. A write while it holds 64 is dropped and does not change the level or the queued data.
- R8: With control bit 18 at 0, request-to-send is held asserted. With control bit 18 at 1, it is deasserted while the receive level is at or above the threshold and asserted while it is below.
- R9: Threshold select bits 20:19 give a threshold of 8 for code 0, 16 for code 1, 32 for code 2 and 48 for code 3.
- R10: With control bit 21 at 0, asserted request-to-send drives the pin to 1. With control bit 21 at 1, asserted drives it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe into the transmit queue |
| wr_data | input | 8 | Byte to queue |
| rate | input | 8 | Bit period select, 14*(rate+1) cycles |
| cts_in | input | 1 | Clear-to-send input pin |
| rx_level | input | 8 | Fill level of the external receive queue |
| ctrl | input | 22 | Control word: 8 break, 14 flow enable, 15 clear-to-send invert, 18 auto request, 20:19 threshold, 21 request invert |
| tx_line | output | 1 | Serial output line |
| rts_out | output | 1 | Request-to-send output pin |
| tx_level | output | 8 | Bytes waiting in the transmit queue |

## Verification
Frames are checked at the centre of each bit for bytes with alternating, sparse, all-zero and all-one patterns, at two rate settings. A wrong bit order, a wrong period or a stuck bit each shows up as a different mismatch. The queue is filled past capacity while the handshake is blocked and then drained, which separates a dropped overflow write from one that corrupts the data or the order. A table of receive levels sits one below and exactly at each threshold, under both polarities, so it can separate an off-by-one compare, a wrong threshold code and a missing inversion. The handshake is also dropped in the middle of a frame, to show that the frame already started finishes and the next one waits.

// File: rtl/hstx_pkg.sv
package hstx_pkg;
  localparam int CTRL_W    = 22;
  localparam int B_BREAK   = 8;
  localparam int B_CTS_EN  = 14;
  localparam int B_CTS_INV = 15;
  localparam int B_RTS_EN  = 18;
  localparam int B_THR_LO  = 19;
  localparam int B_RTS_INV = 21;
  localparam int OSR       = 14;
  localparam int FRAME_BITS = 10;

  function automatic logic [7:0] thr_of(input logic [1:0] sel);
    case (sel)
      2'd0: thr_of = 8'd8;
      2'd1: thr_of = 8'd16;
      2'd2: thr_of = 8'd32;
      default: thr_of = 8'd48;
    endcase
  endfunction
endpackage

// File: rtl/hstx_fifo.sv
module hstx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  parameter int LW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic [LW-1:0] level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic full, do_wr, do_rd;

  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);
  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & ~empty;
  assign rd_data = mem[rd_ptr];
  assign level = LW'(count);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10: count <= count + 1'b1;
        2'b01: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: a write into a full queue with no read leaves the count unchanged
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (count == $past(count)));
  // R7: the count never exceeds the capacity
  a_r7_level_bound: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
endmodule

// File: rtl/hstx_shifter.sv
module hstx_shifter #(
  parameter int RW  = 8,
  parameter int DW  = 8,
  parameter int OSR = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] rate,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          busy,
  output logic          line_bit
);
  localparam int TW = RW + $clog2(OSR) + 1;
  localparam int SW = DW + 2;
  localparam int BW = $clog2(SW);

  logic [TW-1:0] bitlen, tick;
  logic [SW-1:0] sh;
  logic [BW-1:0] bcnt;

  assign bitlen   = (TW'(rate) + TW'(1)) * TW'(OSR);
  assign line_bit = sh[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sh   <= '1;
      tick <= '0;
      bcnt <= '0;
    end else if (load && !busy) begin
      sh   <= {1'b1, load_data, 1'b0};
      busy <= 1'b1;
      tick <= '0;
      bcnt <= '0;
    end else if (busy) begin
      if (tick == bitlen - 1'b1) begin
        tick <= '0;
        sh   <= {1'b1, sh[SW-1:1]};
        if (bcnt == BW'(SW - 1)) busy <= 1'b0;
        else bcnt <= bcnt + 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  // R2: a frame begins with a low start bit
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    (load && !busy) |=> (line_bit == 1'b0));
  // R1: the line bit is high whenever no frame runs
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line_bit);
endmodule

// File: rtl/hstx_rts.sv
module hstx_rts #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          inv,
  input  logic [1:0]    sel,
  input  logic [LW-1:0] rx_level,
  output logic          rts
);
  import hstx_pkg::*;
  logic [LW-1:0] thr;
  logic          ready;

  assign thr   = LW'(thr_of(sel));
  assign ready = ~en | (rx_level < thr);

  always_ff @(posedge clk) begin
    if (rst) rts <= 1'b1;
    else     rts <= ready ^ inv;
  end

  // R8: with automatic mode on and the level at threshold, the pin shows deasserted
  a_r8_rts_stop: assert property (@(posedge clk) disable iff (rst)
    (en && rx_level >= thr) |=> (rts == $past(inv)));
  // R8: with automatic mode off the pin shows asserted
  a_r8_rts_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (rts == !$past(inv)));
endmodule

// File: rtl/hs_serial_tx.sv
module hs_serial_tx #(
  parameter int DEPTH = 64,
  parameter int LW    = 8,
  parameter int RW    = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [7:0]                wr_data,
  input  logic [RW-1:0]             rate,
  input  logic                      cts_in,
  input  logic [LW-1:0]             rx_level,
  input  logic [hstx_pkg::CTRL_W-1:0] ctrl,
  output logic                      tx_line,
  output logic                      rts_out,
  output logic [LW-1:0]             tx_level
);
  import hstx_pkg::*;

  logic [1:0] cts_sync;
  logic       cts_ok, busy, empty, start, line_bit;
  logic [7:0] head;

  always_ff @(posedge clk) begin
    if (rst) cts_sync <= 2'b00;
    else     cts_sync <= {cts_sync[0], cts_in};
  end

  assign cts_ok = ~ctrl[B_CTS_EN] | (cts_sync[1] ^ ctrl[B_CTS_INV]);
  assign start  = ~busy & ~empty & cts_ok;

  hstx_fifo #(.DW(8), .DEPTH(DEPTH), .LW(LW)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(start), .rd_data(head), .empty(empty), .level(tx_level)
  );

  hstx_shifter #(.RW(RW), .DW(8), .OSR(OSR)) u_shift (
    .clk(clk), .rst(rst), .rate(rate), .load(start), .load_data(head),
    .busy(busy), .line_bit(line_bit)
  );

  hstx_rts #(.LW(LW)) u_rts (
    .clk(clk), .rst(rst), .en(ctrl[B_RTS_EN]), .inv(ctrl[B_RTS_INV]),
    .sel(ctrl[B_THR_LO+1:B_THR_LO]), .rx_level(rx_level), .rts(rts_out)
  );

  always_ff @(posedge clk) begin
    if (rst) tx_line <= 1'b1;
    else     tx_line <= ~ctrl[B_BREAK] & line_bit;
  end

  // R4: a forced break drives the line low on the next edge
  a_r4_break_low: assert property (@(posedge clk) disable iff (rst)
    ctrl[B_BREAK] |=> !tx_line);
  // R5: with the handshake blocked, an idle transmitter stays idle
  a_r5_cts_hold: assert property (@(posedge clk) disable iff (rst)
    (!cts_ok && !busy) |=> !busy);
endmodule

// File: tb/hs_serial_tx_tb.sv
module hs_serial_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rate = '0;
  logic        cts_in = 1'b0;
  logic [7:0]  rx_level = '0;
  logic [21:0] ctrl = '0;
  logic        tx_line, rts_out;
  logic [7:0]  tx_level;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hs_serial_tx dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rate(rate),
    .cts_in(cts_in), .rx_level(rx_level), .ctrl(ctrl),
    .tx_line(tx_line), .rts_out(rts_out), .tx_level(tx_level)
  );

  // {sel[1:0], inv, auto, level[7:0], expected pin}
  localparam logic [12:0] VEC [12] = '{
    {2'd0, 1'b0, 1'b0, 8'd100, 1'b1},
    {2'd0, 1'b1, 1'b0, 8'd100, 1'b0},
    {2'd0, 1'b0, 1'b1, 8'd7,   1'b1},
    {2'd0, 1'b0, 1'b1, 8'd8,   1'b0},
    {2'd1, 1'b0, 1'b1, 8'd15,  1'b1},
    {2'd1, 1'b0, 1'b1, 8'd16,  1'b0},
    {2'd2, 1'b0, 1'b1, 8'd31,  1'b1},
    {2'd2, 1'b0, 1'b1, 8'd32,  1'b0},
    {2'd3, 1'b0, 1'b1, 8'd47,  1'b1},
    {2'd3, 1'b0, 1'b1, 8'd48,  1'b0},
    {2'd3, 1'b1, 1'b1, 8'd48,  1'b1},
    {2'd3, 1'b1, 1'b1, 8'd47,  1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic recv(input int bl, input bit drop, input string tag,
                      input logic [7:0] exp);
    logic [7:0] b;
    int n;
    n = 0;
    while (tx_line !== 1'b0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " start found"}, int'(n < 20000), 1);
    if (drop) cts_in = ~cts_in;
    repeat (bl / 2) @(negedge clk);
    check({tag, " start bit"}, int'(tx_line), 0);
    for (int i = 0; i < 8; i++) begin
      repeat (bl) @(negedge clk);
      b[i] = tx_line;
    end
    check({tag, " data"}, int'(b), int'(exp));
    repeat (bl) @(negedge clk);
    check({tag, " stop bit"}, int'(tx_line), 1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    do_reset();
    // R1: reset state
    check("R1 line idle", int'(tx_line), 1);
    check("R3 level empty", int'(tx_level), 0);
    check("R8 rts default", int'(rts_out), 1);

    // R8 R9 R10: vector table walk
    foreach (VEC[k]) begin
      @(negedge clk);
      ctrl = '0;
      ctrl[20:19] = VEC[k][12:11];
      ctrl[21] = VEC[k][10];
      ctrl[18] = VEC[k][9];
      rx_level = VEC[k][8:1];
      repeat (2) @(negedge clk);
      if (!VEC[k][9]) check("R8 rts", int'(rts_out), int'(VEC[k][0]));
      else if (VEC[k][10]) check("R10 rts", int'(rts_out), int'(VEC[k][0]));
      else check("R9 rts", int'(rts_out), int'(VEC[k][0]));
    end
    ctrl = '0;

    // R2: frame patterns at rate 0
    put(8'h55); recv(14, 1'b0, "R2 0x55", 8'h55);
    put(8'hA3); recv(14, 1'b0, "R2 0xA3", 8'hA3);
    put(8'h00); recv(14, 1'b0, "R2 0x00", 8'h00);
    put(8'hFF); recv(14, 1'b0, "R2 0xFF", 8'hFF);
    repeat (20) @(negedge clk);
    check("R1 idle after frame", int'(tx_line), 1);
    // R2: slower rate
    rate = 8'd1;
    put(8'h96); recv(28, 1'b0, "R2 rate1", 8'h96);
    rate = 8'd0;
    repeat (40) @(negedge clk);

    // R4: break forcing
    ctrl[8] = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 break low", int'(tx_line), 0);
    repeat (50) @(negedge clk);
    check("R4 break held", int'(tx_line), 0);
    ctrl[8] = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 break released", int'(tx_line), 1);

    // R6: inverted handshake, input high means blocked
    ctrl[14] = 1'b1; ctrl[15] = 1'b1; cts_in = 1'b1;
    repeat (4) @(negedge clk);
    put(8'h3C);
    ok = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tx_line !== 1'b1) ok = 1'b0;
    end
    check("R6 blocked line high", int'(ok), 1);
    check("R6 blocked level", int'(tx_level), 1);
    cts_in = 1'b0;
    recv(14, 1'b0, "R6 released", 8'h3C);
    ctrl[15] = 1'b0;

    // R5: drop handshake mid-frame
    cts_in = 1'b1;
    repeat (4) @(negedge clk);
    put(8'h81); put(8'h42);
    recv(14, 1'b1, "R5 current frame", 8'h81);
    ok = 1'b1;
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (tx_line !== 1'b1) ok = 1'b0;
    end
    check("R5 next held", int'(ok), 1);
    check("R5 level held", int'(tx_level), 1);
    cts_in = 1'b1;
    recv(14, 1'b0, "R5 resumed", 8'h42);

    // R7: overfill while blocked, then drain in order (R3)
    do_reset();
    ctrl = '0; ctrl[14] = 1'b1; cts_in = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 70; i++) put(8'(i + 8'h10));
    check("R7 level capped", int'(tx_level), 64);
    cts_in = 1'b1;
    for (int i = 0; i < 64; i++) recv(14, 1'b0, "R3 drain order", 8'(i + 8'h10));
    repeat (40) @(negedge clk);
    check("R3 level drained", int'(tx_level), 0);
    check("R1 idle at end", int'(tx_line), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule